// File: doc/BRIEF.md
# Keyboard and Display Character Port

This block sits on a processor's memory-mapped bus and gives software a simple way to take characters from a keyboard and send characters to a display. It has four registers: one that holds the last key character, one that holds the character going out, a read-only status word, and a control word with two enable bits.

The status word carries two ready flags. The input-ready flag rises when the keyboard delivers a character and falls when software reads the input data register. The output-ready flag rises when the display reports it can take a character and falls when software writes the output data register. A polling loop can test these flags before each transfer.

Each ready flag, gated by its own enable bit, also forms an interrupt-request flag. A single interrupt line is raised whenever either request flag is set. If a key arrives before the previous one was read, the new character replaces the old one and an overrun flag is set.

Top module: `kbd_disp_if`

## Requirements
- R1: A cycle with `key_valid` high stores `key_char` in the input data register (offset 0) and sets the input-ready flag, status bit 0, from the next cycle.
- R2: A read of offset 0 returns the stored character in the same cycle and clears input-ready from the next cycle. If `key_valid` is high in that same cycle, input-ready stays set and the new character is stored.
- R3: A cycle with `disp_ready` high sets the output-ready flag, status bit 1, from the next cycle. This takes priority over a write to offset 1 in the same cycle.
- R4: A write to offset 1 stores `bus_wdata` in the output data register and clears output-ready. In the next cycle `disp_strobe` is high for exactly one cycle, with the written value on `disp_char`.
- R5: The control register is at offset 3. Bit 0 is the keyboard enable and bit 1 is the display enable. Both reset to 0, and the upper bits read back as 0.
- R6: Status bit 2 is input-ready AND keyboard enable. Status bit 3 is output-ready AND display enable.
- R7: `irq` is high exactly when status bit 2 or status bit 3 is high.
- R8: A key that arrives while input-ready is set, in a cycle with no read of offset 0, sets the overrun flag, status bit 4. A read of offset 0 with no such key clears the flag.
- R9: The status register is at offset 2 and is read-only: a write to it changes no flag. `bus_rdata` is 0 in any cycle in which `bus_rd` is low.
- R10: After reset, all flags, both enables and both data registers are 0, and `irq` and `disp_strobe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register offset |
| bus_rd | input | 1 | Read strobe; the data is valid in the same cycle |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, 0 when no read is in progress |
| key_valid | input | 1 | One-cycle pulse marking a new key character |
| key_char | input | DW | Key character |
| disp_ready | input | 1 | Pulse from the display: it can take a character |
| disp_char | output | DW | Character presented to the display |
| disp_strobe | output | 1 | One-cycle pulse: a new character is on `disp_char` |
| irq | output | 1 | Combined interrupt request |

## Verification
The enable settings are swept exhaustively: all four control values are crossed with all four combinations of the two ready flags. This separates the gating of each request flag, and of the combined line, from the raw ready flags. The key path is tried with sixteen distinct characters, which exposes stuck or swapped data bits. Separate patterns check what happens when two events land in the same cycle: a key with a read, a display-ready pulse with a write, and a second key before the first read. These patterns tell the priority rules apart from the overrun rule. Writes to the status offset and wide writes to the control offset show that only the defined bits are held.

// File: rtl/kbd_disp_if.sv
module kbd_disp_if #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    bus_addr,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          key_valid,
  input  logic [DW-1:0] key_char,
  input  logic          disp_ready,
  output logic [DW-1:0] disp_char,
  output logic          disp_strobe,
  output logic          irq
);
  localparam logic [1:0] OFS_IN  = 2'd0;
  localparam logic [1:0] OFS_OUT = 2'd1;
  localparam logic [1:0] OFS_ST  = 2'd2;
  localparam logic [1:0] OFS_CTL = 2'd3;
  localparam int         STW     = 5;

  logic [DW-1:0] in_data, out_data;
  logic in_rdy, out_rdy, ovr, kbd_en, disp_en, strobe_q;

  wire rd_in  = bus_rd && bus_addr == OFS_IN;
  wire wr_out = bus_wr && bus_addr == OFS_OUT;
  wire wr_ctl = bus_wr && bus_addr == OFS_CTL;

  wire kirq = in_rdy && kbd_en;
  wire dirq = out_rdy && disp_en;
  wire [STW-1:0] status = {ovr, dirq, kirq, out_rdy, in_rdy};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_data  <= '0;
      out_data <= '0;
      in_rdy   <= 1'b0;
      out_rdy  <= 1'b0;
      ovr      <= 1'b0;
      kbd_en   <= 1'b0;
      disp_en  <= 1'b0;
      strobe_q <= 1'b0;
    end else begin
      if (key_valid) in_data <= key_char;
      if (key_valid) in_rdy <= 1'b1;
      else if (rd_in) in_rdy <= 1'b0;
      if (key_valid && in_rdy && !rd_in) ovr <= 1'b1;
      else if (rd_in) ovr <= 1'b0;
      if (wr_out) out_data <= bus_wdata;
      if (disp_ready) out_rdy <= 1'b1;
      else if (wr_out) out_rdy <= 1'b0;
      strobe_q <= wr_out;
      if (wr_ctl) begin
        kbd_en  <= bus_wdata[0];
        disp_en <= bus_wdata[1];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        OFS_IN:  bus_rdata = in_data;
        OFS_OUT: bus_rdata = out_data;
        OFS_ST:  bus_rdata[STW-1:0] = status;
        default: bus_rdata[1:0] = {disp_en, kbd_en};
      endcase
    end
  end

  assign disp_char   = out_data;
  assign disp_strobe = strobe_q;
  assign irq         = kirq || dirq;
endmodule

module kbd_disp_if_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    bus_addr,
  input logic          bus_rd,
  input logic          bus_wr,
  input logic [DW-1:0] bus_wdata,
  input logic          key_valid,
  input logic          disp_ready,
  input logic [DW-1:0] disp_char,
  input logic          disp_strobe,
  input logic          irq,
  input logic          in_rdy,
  input logic          out_rdy,
  input logic          ovr,
  input logic          kbd_en,
  input logic          disp_en
);
  p_key_sets_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |=> in_rdy);
  p_read_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 2'd0 && !key_valid) |=> !in_rdy);
  p_disp_sets_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    disp_ready |=> out_rdy);
  p_write_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd1) |=> (disp_strobe && disp_char == $past(bus_wdata)));
  p_strobe_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    disp_strobe |=> !disp_strobe || $past(bus_wr && bus_addr == 2'd1));
  p_irq_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!kbd_en && !disp_en) |-> !irq);
  p_irq_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((in_rdy && kbd_en) || (out_rdy && disp_en)));
  p_overrun_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (key_valid && in_rdy && !(bus_rd && bus_addr == 2'd0)) |=> ovr);
  p_status_ro_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd2 && !key_valid && !disp_ready && !bus_rd)
      |=> ($stable(in_rdy) && $stable(out_rdy) && $stable(ovr)));
endmodule

bind kbd_disp_if kbd_disp_if_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
  .bus_wr(bus_wr), .bus_wdata(bus_wdata), .key_valid(key_valid),
  .disp_ready(disp_ready), .disp_char(disp_char), .disp_strobe(disp_strobe),
  .irq(irq), .in_rdy(in_rdy), .out_rdy(out_rdy), .ovr(ovr),
  .kbd_en(kbd_en), .disp_en(disp_en)
);

// File: tb/sim_kbd_disp_if.sv
`timescale 1ns/1ps
module sim_kbd_disp_if;
  localparam int DW = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic bus_rd = 0, bus_wr = 0, key_valid = 0, disp_ready = 0;
  logic [DW-1:0] bus_wdata = '0, key_char = '0;
  logic [DW-1:0] bus_rdata, disp_char;
  logic disp_strobe, irq;
  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  kbd_disp_if #(.DW(DW)) u0 (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [DW-1:0] v);
    bus_addr = a; bus_rd = 1; #1;
    v = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] v);
    bus_addr = a; bus_wdata = v; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic key(input logic [DW-1:0] c);
    key_char = c; key_valid = 1;
    @(negedge clk); key_valid = 0;
  endtask

  task automatic dready;
    disp_ready = 1;
    @(negedge clk); disp_ready = 0;
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [DW-1:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10: reset state
    rd(2'd2, v); chk("R10 status", v, 0);
    rd(2'd3, v); chk("R10 control", v, 0);
    rd(2'd1, v); chk("R10 out data", v, 0);
    chk("R10 irq", irq, 0);
    chk("R10 strobe", disp_strobe, 0);
    // R9: idle read data
    #1 chk("R9 idle rdata", bus_rdata, 0);

    // R1 / R2: sweep of key characters
    for (int i = 0; i < 16; i++) begin
      logic [DW-1:0] c;
      c = DW'(i * 17 + 3);
      key(c);
      rd(2'd2, v); chk("R1 in_ready", v & 8'h01, 1);
      rd(2'd0, v); chk("R2 data", v, c);
      rd(2'd2, v); chk("R2 cleared", v & 8'h01, 0);
    end

    // R2: key in same cycle as read keeps ready, new char stored
    key(8'h41);
    bus_addr = 2'd0; bus_rd = 1; key_char = 8'h42; key_valid = 1; #1;
    chk("R2 read old", bus_rdata, 8'h41);
    @(negedge clk); bus_rd = 0; key_valid = 0;
    rd(2'd2, v); chk("R2 ready kept", v & 8'h11, 8'h01);
    rd(2'd0, v); chk("R2 new char", v, 8'h42);

    // R8: overrun
    key(8'h10); key(8'h20);
    rd(2'd2, v); chk("R8 overrun set", v & 8'h11, 8'h11);
    rd(2'd0, v); chk("R8 newest kept", v, 8'h20);
    rd(2'd2, v); chk("R8 overrun cleared", v & 8'h11, 0);

    // R3 / R4: display path
    dready;
    rd(2'd2, v); chk("R3 out_ready", v & 8'h02, 2);
    wr(2'd1, 8'h5A);
    chk("R4 strobe", disp_strobe, 1);
    chk("R4 disp_char", disp_char, 8'h5A);
    @(negedge clk);
    chk("R4 strobe single", disp_strobe, 0);
    rd(2'd2, v); chk("R4 out_ready cleared", v & 8'h02, 0);
    rd(2'd1, v); chk("R4 readback", v, 8'h5A);
    // R3: ready pulse with write in same cycle wins
    bus_addr = 2'd1; bus_wdata = 8'hC3; bus_wr = 1; disp_ready = 1;
    @(negedge clk); bus_wr = 0; disp_ready = 0;
    chk("R3 write strobe", disp_strobe, 1);
    rd(2'd2, v); chk("R3 priority", v & 8'h02, 2);
    wr(2'd1, 8'h00);

    // R5: control upper bits
    wr(2'd3, 8'hFF);
    rd(2'd3, v); chk("R5 control mask", v, 8'h03);

    // R6 / R7: exhaustive enables x ready flags
    for (int ctl = 0; ctl < 4; ctl++) begin
      for (int fl = 0; fl < 4; fl++) begin
        int e;
        wr(2'd3, DW'(ctl));
        rd(2'd0, v);
        wr(2'd1, 8'h00);
        if (fl[0]) key(8'h77);
        if (fl[1]) dready;
        e = fl | ((fl & ctl) << 2);
        rd(2'd2, v); chk("R6 status", v, e);
        rd(2'd3, v); chk("R5 control", v, ctl);
        chk("R7 irq", irq, ((fl & ctl) != 0) ? 1 : 0);
      end
    end

    // R9: status write ignored
    rd(2'd2, v);
    wr(2'd2, 8'h00);
    begin
      logic [DW-1:0] w;
      rd(2'd2, w); chk("R9 status ro", w, v);
    end
    wr(2'd2, 8'hFF);
    rd(2'd2, v); chk("R9 status ro ones", v, 8'h0F);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule